// File: doc/BRIEF.md
# Video Sync Timing Detector

This block watches a raster video stream made of a horizontal sync, a vertical sync and a data-enable line, all sampled on the pixel clock. It needs no setup. From the stream alone it works out which level of each sync line is the asserted one, how long each sync pulse lasts, how many pixels make up a full line and how many lines make up a full frame, and how large the active picture is. A line is counted as one period of the horizontal sync. The vertical sync is sampled once per line.

The figures are frozen into a snapshot at each frame boundary, which is the rising edge of the vertical sync as sampled once per line. Software reads the snapshot through a small AXI4-Lite read-only slave that runs on the same pixel clock. A lock flag shows whether the incoming timing has settled. Software uses the resolution and the lock flag to decide whether to switch the video pipeline over to this source.

Top module: `vid_timing_detect`

## Requirements
- R1: The total pixels per line (word index 2, byte address 0x08) equals the number of clocks between two rising edges of the horizontal sync. Status bit 1 is 1 when the horizontal sync is high for less than half of a line (active-high pulse) and 0 otherwise.
- R2: The horizontal sync width (index 4, 0x10) equals the number of clocks in the shorter of the two levels of a line.
- R3: The total lines per frame (index 3, 0x0C) equals the number of lines between two frame boundaries. The vertical sync width in lines (index 5, 0x14) equals the number of lines the shorter vertical level lasts. Status bit 2 is 1 when the vertical pulse is active-high.
- R4: The active width (index 0, 0x00) equals the length in clocks of the last data-enable run. The active height (index 1, 0x01 word, byte address 0x04) equals the number of data-enable runs that begin between two frame boundaries.
- R5: Status bit 0 (lock) is 0 until two consecutive frame snapshots are identical. It becomes 1 at the second matching frame boundary and changes only at a frame boundary.
- R6: Lock returns to 0 at the first frame boundary whose snapshot differs from the one before it.
- R7: Every readable value changes only at a frame boundary. A read in the middle of a frame returns the values from the previous frame even after the input timing has changed.
- R8: A read of any word index outside 0 to 6 (for example 0x1C) returns zero with response OKAY (2'b00).
- R9: An accepted read address yields rvalid one clock later. rvalid and rdata then stay unchanged until rready is high.
- R10: After reset, rvalid is low and every register, including the status word (index 6, 0x18), reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; clocks both the measurement logic and the register slave |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_i | input | 1 | Horizontal sync, either polarity |
| vsync_i | input | 1 | Vertical sync, either polarity |
| de_i | input | 1 | Data enable, high during active pixels |
| s_araddr | input | ADDR_W | Read byte address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |

## Verification
The bench builds the block with its default parameters: 12-bit counters, which cover a 2200 by 1125 raster, a 5-bit address and a 32-bit data word. With these counter widths it can run a series of small rasters, a few hundred to about a thousand clocks per frame. That makes room for every combination of the two sync polarities, several frames per timing, a timing switch in the middle of the run and the lock sequence after reset. A full 1080p frame would be far too long for the cycle budget.

// File: rtl/vtd_pkg.sv
package vtd_pkg;
    // word index of each readable register
    typedef enum logic [2:0] {
        REG_ACT_W   = 3'd0,
        REG_ACT_H   = 3'd1,
        REG_TOT_PIX = 3'd2,
        REG_TOT_LIN = 3'd3,
        REG_HS_LEN  = 3'd4,
        REG_VS_LEN  = 3'd5,
        REG_STATUS  = 3'd6
    } vtd_reg_e;

    localparam int STAT_LOCK = 0;
    localparam int STAT_HPOL = 1;
    localparam int STAT_VPOL = 2;
    localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/vtd_sync_meas.sv
// Measures the period and the shorter-level width of one sync signal,
// sampled on tick_i; a rising edge of the sampled level opens each period.
module vtd_sync_meas #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             sig_i,
    output logic             edge_o,
    output logic             valid_o,
    output logic [CNT_W-1:0] period_o,
    output logic [CNT_W-1:0] width_o,
    output logic             act_high_o
);
    typedef struct packed {
        logic             prev;
        logic             have;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] high;
        logic             valid;
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] width;
        logic             act_high;
    } st_t;

    st_t st_d, st_q;
    logic             rise;
    logic [CNT_W-1:0] low_len;
    logic             hi_short;

    always_comb begin
        st_d     = st_q;
        st_d.valid = 1'b0;
        rise     = tick_i & sig_i & ~st_q.prev;
        low_len  = st_q.cnt - st_q.high;
        hi_short = st_q.high < low_len;
        if (tick_i) begin
            st_d.prev = sig_i;
            if (rise) begin
                if (st_q.have) begin
                    st_d.valid    = 1'b1;
                    st_d.period   = st_q.cnt;
                    st_d.act_high = hi_short;
                    st_d.width    = hi_short ? st_q.high : low_len;
                end
                st_d.have = 1'b1;
                st_d.cnt  = {{(CNT_W-1){1'b0}}, 1'b1};
                st_d.high = {{(CNT_W-1){1'b0}}, 1'b1};
            end else begin
                st_d.cnt = (st_q.cnt == '1) ? st_q.cnt : st_q.cnt + 1'b1;
                if (sig_i && st_q.high != '1)
                    st_d.high = st_q.high + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign edge_o     = rise;
    assign valid_o    = st_q.valid;
    assign period_o   = st_q.period;
    assign width_o    = st_q.width;
    assign act_high_o = st_q.act_high;

    // R2
    width_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ({1'b0, width_o} << 1) <= {1'b0, period_o});
endmodule

// File: rtl/vtd_active_meas.sv
// Measures data-enable run length and the number of runs per frame.
module vtd_active_meas #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             de_i,
    input  logic             frame_i,
    output logic [CNT_W-1:0] width_o,
    output logic [CNT_W-1:0] height_o
);
    typedef struct packed {
        logic             prev;
        logic [CNT_W-1:0] run;
        logic [CNT_W-1:0] width;
        logic [CNT_W-1:0] lines;
        logic [CNT_W-1:0] height;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = de_i;
        if (de_i && st_q.run != '1)
            st_d.run = st_q.run + 1'b1;
        if (!de_i && st_q.prev) begin
            st_d.width = st_q.run;
            st_d.run   = '0;
        end
        if (de_i && !st_q.prev && st_q.lines != '1)
            st_d.lines = st_q.lines + 1'b1;
        if (frame_i) begin
            st_d.height = st_q.lines;
            st_d.lines  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign width_o  = st_q.width;
    assign height_o = st_q.height;

    // R4
    width_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        de_i |=> $stable(width_o));
endmodule

// File: rtl/vtd_regs.sv
// Read-only AXI4-Lite style slave over the frame snapshot.
module vtd_regs
    import vtd_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] araddr_i,
    input  logic              arvalid_i,
    output logic              arready_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic [1:0]        rresp_o,
    output logic              rvalid_o,
    input  logic              rready_i,
    input  logic [CNT_W-1:0]  act_w_i,
    input  logic [CNT_W-1:0]  act_h_i,
    input  logic [CNT_W-1:0]  tot_pix_i,
    input  logic [CNT_W-1:0]  tot_lin_i,
    input  logic [CNT_W-1:0]  hs_len_i,
    input  logic [CNT_W-1:0]  vs_len_i,
    input  logic              hpol_i,
    input  logic              vpol_i,
    input  logic              locked_i
);
    localparam int IDX_W = ADDR_W - 2;
    localparam int PAD_W = DATA_W - CNT_W;

    typedef struct packed {
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
    } st_t;

    st_t st_d, st_q;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] sel;

    assign idx = araddr_i[ADDR_W-1:2];

    always_comb begin
        sel = '0;
        case (idx)
            IDX_W'(REG_ACT_W):   sel = {{PAD_W{1'b0}}, act_w_i};
            IDX_W'(REG_ACT_H):   sel = {{PAD_W{1'b0}}, act_h_i};
            IDX_W'(REG_TOT_PIX): sel = {{PAD_W{1'b0}}, tot_pix_i};
            IDX_W'(REG_TOT_LIN): sel = {{PAD_W{1'b0}}, tot_lin_i};
            IDX_W'(REG_HS_LEN):  sel = {{PAD_W{1'b0}}, hs_len_i};
            IDX_W'(REG_VS_LEN):  sel = {{PAD_W{1'b0}}, vs_len_i};
            IDX_W'(REG_STATUS): begin
                sel[STAT_LOCK] = locked_i;
                sel[STAT_HPOL] = hpol_i;
                sel[STAT_VPOL] = vpol_i;
            end
            default: sel = '0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (arvalid_i && !st_q.rvalid) begin
            st_d.rvalid = 1'b1;
            st_d.rdata  = sel;
        end else if (st_q.rvalid && rready_i) begin
            st_d.rvalid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign arready_o = ~st_q.rvalid;
    assign rvalid_o  = st_q.rvalid;
    assign rdata_o   = st_q.rdata;
    assign rresp_o   = RESP_OKAY;

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid_o && !rready_i) |=> (rvalid_o && $stable(rdata_o)));
    // R9
    read_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arvalid_i && arready_o) |=> rvalid_o);
endmodule

// File: rtl/vid_timing_detect.sv
module vid_timing_detect #(
    parameter int CNT_W  = 12,
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync_i,
    input  logic              vsync_i,
    input  logic              de_i,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [DATA_W-1:0] s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready
);
    typedef struct packed {
        logic [CNT_W-1:0] aw;
        logic [CNT_W-1:0] ah;
        logic [CNT_W-1:0] ht;
        logic [CNT_W-1:0] vt;
        logic [CNT_W-1:0] hsw;
        logic [CNT_W-1:0] vsw;
        logic             hpol;
        logic             vpol;
    } snap_t;

    typedef struct packed {
        logic  hs;
        logic  vs;
        logic  de;
        logic  h_seen;
        logic  snap_ok;
        logic  locked;
        snap_t snap;
    } st_t;

    st_t st_d, st_q;

    logic             h_edge, h_valid, h_pol, v_edge, v_valid, v_pol;
    logic [CNT_W-1:0] h_per, h_wid, v_per, v_wid, a_wid, a_hgt;
    snap_t            fresh;

    vtd_sync_meas #(.CNT_W(CNT_W)) h_meas_i (
        .clk(clk), .rst_n(rst_n), .tick_i(1'b1), .sig_i(st_q.hs),
        .edge_o(h_edge), .valid_o(h_valid), .period_o(h_per),
        .width_o(h_wid), .act_high_o(h_pol)
    );

    vtd_sync_meas #(.CNT_W(CNT_W)) v_meas_i (
        .clk(clk), .rst_n(rst_n), .tick_i(h_edge), .sig_i(st_q.vs),
        .edge_o(v_edge), .valid_o(v_valid), .period_o(v_per),
        .width_o(v_wid), .act_high_o(v_pol)
    );

    vtd_active_meas #(.CNT_W(CNT_W)) act_meas_i (
        .clk(clk), .rst_n(rst_n), .de_i(st_q.de), .frame_i(v_edge),
        .width_o(a_wid), .height_o(a_hgt)
    );

    always_comb begin
        fresh = '{aw: a_wid, ah: a_hgt, ht: h_per, vt: v_per,
                  hsw: h_wid, vsw: v_wid, hpol: h_pol, vpol: v_pol};
        st_d    = st_q;
        st_d.hs = hsync_i;
        st_d.vs = vsync_i;
        st_d.de = de_i;
        if (h_valid)
            st_d.h_seen = 1'b1;
        if (v_valid && st_q.h_seen) begin
            st_d.locked  = st_q.snap_ok && (fresh == st_q.snap);
            st_d.snap    = fresh;
            st_d.snap_ok = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    vtd_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .araddr_i(s_araddr), .arvalid_i(s_arvalid), .arready_o(s_arready),
        .rdata_o(s_rdata), .rresp_o(s_rresp), .rvalid_o(s_rvalid),
        .rready_i(s_rready),
        .act_w_i(st_q.snap.aw), .act_h_i(st_q.snap.ah),
        .tot_pix_i(st_q.snap.ht), .tot_lin_i(st_q.snap.vt),
        .hs_len_i(st_q.snap.hsw), .vs_len_i(st_q.snap.vsw),
        .hpol_i(st_q.snap.hpol), .vpol_i(st_q.snap.vpol),
        .locked_i(st_q.locked)
    );

    // R5
    lock_at_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.locked) |-> $past(v_valid));
    // R6
    lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.locked) |-> $past(v_valid));
    // R7
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(v_valid) |-> $stable(st_q.snap));
endmodule

// File: tb/vid_timing_detect_tb_top.sv
module vid_timing_detect_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hs = 1'b0, vs = 1'b0, de = 1'b0;
    logic [4:0]  araddr = '0;
    logic        arvalid = 1'b0, rready = 1'b1;
    logic        arready, rvalid;
    logic [31:0] rdata;
    logic [1:0]  rresp;

    int  total = 0, bad = 0;
    int  cfg_sel = 0, frame_cnt = 0, line_y = 0;
    bit  gen_en = 1'b0, done = 1'b0;

    // HT, HA, HFP, HSW, VT, VA, VFP, VSW, HPOL, VPOL
    localparam int CFG [4][10] = '{
        '{40, 24, 4, 5, 20, 12, 2, 3, 1, 1},
        '{48, 30, 3, 6, 24, 16, 2, 2, 0, 1},
        '{36, 20, 5, 4, 18, 10, 1, 4, 1, 0},
        '{44, 28, 2, 7, 22, 14, 3, 3, 0, 0}
    };

    always #10 clk = ~clk;

    vid_timing_detect dut_i (
        .clk(clk), .rst_n(rst_n), .hsync_i(hs), .vsync_i(vs), .de_i(de),
        .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
        .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready)
    );

    // raster source; picks up cfg_sel at the start of every frame
    initial begin
        wait (gen_en);
        forever begin
            int c;
            c = cfg_sel;
            frame_cnt++;
            for (int y = 0; y < CFG[c][4]; y++) begin
                line_y = y;
                for (int x = 0; x < CFG[c][0]; x++) begin
                    bit hon, von;
                    @(negedge clk);
                    hon = (x >= CFG[c][1] + CFG[c][2]) && (x < CFG[c][1] + CFG[c][2] + CFG[c][3]);
                    von = (y >= CFG[c][5] + CFG[c][6]) && (y < CFG[c][5] + CFG[c][6] + CFG[c][7]);
                    hs = (CFG[c][8] != 0) ? hon : !hon;
                    vs = (CFG[c][9] != 0) ? von : !von;
                    de = (x < CFG[c][1]) && (y < CFG[c][5]);
                end
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic rd(input int addr, output int data);
        @(negedge clk);
        araddr  = 5'(addr);
        arvalid = 1'b1;
        rready  = 1'b1;
        @(posedge clk);
        @(negedge clk);
        arvalid = 1'b0;
        data    = int'(rdata);
        if (!rvalid || rresp != 2'b00) begin
            total++;
            bad++;
            $display("FAIL R9: actual=rvalid %0d resp %0d expected=rvalid 1 resp 0", rvalid, rresp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int v, n, d1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R10 rvalid", int'(rvalid), 0);
        rst_n = 1'b1;
        rd(32'h18, v); chk("R10 status", v, 0);
        rd(32'h00, v); chk("R10 act width", v, 0);
        rd(32'h08, v); chk("R10 total pixels", v, 0);

        // lock sequence from reset with timing 0
        gen_en = 1'b1;
        wait (frame_cnt == 2 && line_y == 17);
        rd(32'h18, v); chk("R5 no lock after one snapshot", v, 6);
        rd(32'h00, v); chk("R4 width first snapshot", v, 24);
        wait (frame_cnt == 3 && line_y == 17);
        rd(32'h18, v); chk("R5 lock after match", v, 7);

        // table walk over all polarity combinations
        for (int i = 0; i < 4; i++) begin
            cfg_sel = i;
            n = frame_cnt;
            wait (frame_cnt == n + 5 && line_y == 2);
            rd(32'h00, v); chk("R4 act width", v, CFG[i][1]);
            rd(32'h04, v); chk("R4 act height", v, CFG[i][5]);
            rd(32'h08, v); chk("R1 total pixels", v, CFG[i][0]);
            rd(32'h0C, v); chk("R3 total lines", v, CFG[i][4]);
            rd(32'h10, v); chk("R2 hsync width", v, CFG[i][3]);
            rd(32'h14, v); chk("R3 vsync width", v, CFG[i][7]);
            rd(32'h18, v); chk("R1 R3 R5 status", v, 1 + 2 * CFG[i][8] + 4 * CFG[i][9]);
        end

        // unmapped address
        rd(32'h1C, v); chk("R8 unmapped", v, 0);

        // read data held while rready is low
        @(negedge clk);
        araddr = 5'h10; arvalid = 1'b1; rready = 1'b0;
        @(posedge clk);
        @(negedge clk);
        arvalid = 1'b0;
        d1 = int'(rdata);
        repeat (3) @(negedge clk);
        chk("R9 rvalid held", int'(rvalid), 1);
        chk("R9 rdata held", int'(rdata), d1);
        rready = 1'b1;
        @(negedge clk);
        chk("R9 rvalid cleared", int'(rvalid), 0);

        // timing switch from 3 back to 0
        cfg_sel = 0;
        n = frame_cnt;
        wait (frame_cnt == n + 1 && line_y == 2);
        rd(32'h10, v); chk("R7 mid-frame keeps old hsync width", v, CFG[3][3]);
        rd(32'h18, v); chk("R7 mid-frame keeps old status", v, 1);
        wait (frame_cnt == n + 1 && line_y == 17);
        rd(32'h18, v); chk("R6 lock dropped", v, 6);
        rd(32'h10, v); chk("R7 new hsync width at boundary", v, CFG[0][3]);
        wait (frame_cnt == n + 4 && line_y == 2);
        rd(32'h18, v); chk("R5 relock", v, 7);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule